// File: doc/BRIEF.md
# Stack Call and Interrupt Sequencer

This block performs the memory side of control-flow changes in a 64-bit processor: subroutine call and return, software break, wait-for-interrupt entry, return from interrupt and reset-vector fetch. Instruction decode presents one command with the jump target, the current PC and the 8-bit status word. The sequencer then moves one byte per clock over a byte-wide memory port. When it finishes, it gives back the new PC, stack pointer and status, and pulses `done` for one cycle.

Each hardware thread owns a 64 KiB stack bank. The bank number is the thread index plus one, and it sits above a 16-bit stack pointer. The stack grows downward. A pushed return address is stored most significant byte first. Interrupt-type entries place one status byte under it. Vectors are 8-byte little-endian words at fixed addresses in bank 0.

Top module: `stk_seq`

## Requirements
- R1: Every stack access uses address {bank, offset} with bank = THREAD_IDX+1. The 16-bit offset is computed modulo 2^16 and never carries into the bank field. Vector reads use bank 0.
- R2: Command code 0 (call) writes PC bytes, most significant first, to SP, SP-1, down to SP-7. It then sets SP to SP-8 and PC to the target. Status out equals the status given with the command.
- R3: Command code 2 (break) pushes the PC like R2. It then writes the unmodified status at SP-8, sets SP to SP-9 and sets status bit 2 (interrupt disable). PC becomes the little-endian word at 0xFFE0.
- R4: Command code 3 (wait-for-interrupt entry) behaves like R3, except that PC comes from the word at 0xFFA0.
- R5: Command code 1 (return) reads PC little-endian from SP+1 up to SP+8 and sets SP to SP+8. Status out equals the status given with the command.
- R6: Command code 4 (return from interrupt) first reads status from SP+1. It then reads PC little-endian from SP+2 up to SP+9 and sets SP to SP+9.
- R7: Command code 5 (reset) loads PC from the thread's vector. That vector is 0xFFC0 for thread 0, or 0xFF50+8*(THREAD_IDX-1) otherwise. SP becomes 0xFFFF and status out equals the status given with the command.
- R8: After hardware reset, SP is 0xFFFF, PC and status are 0, `done` is low and no memory access is made.
- R9: One access is made per cycle: 8 for call, return and reset, 9 for return from interrupt, 17 for break and wait-for-interrupt entry. `done` is high for exactly one cycle, the cycle after the last access.
- R10: A command presented while a sequence is running has no effect. Results, access count and number of `done` pulses are unchanged.
- R11: Command codes 6 and 7 make no access, give no `done` and leave the outputs unchanged.
- R12: `new_pc`, `new_sp` and `new_status` change only in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 3 | Command code |
| cmd_target | input | 64 | Call target address |
| cur_pc | input | 64 | Return address to push |
| cur_status | input | 8 | Current status byte |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid in the access cycle |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 64 | Resulting PC |
| new_sp | output | 16 | Stack pointer |
| new_status | output | 8 | Resulting status |

## Verification
The bench builds the block with THREAD_IDX = 3, so the stack lives in bank 4. The reset vector is then taken from 0xFF60, which exercises the nonzero-thread vector formula and a bank value that is neither 0 nor 1. Because SP starts at 0xFFFF, the first pop wraps to offset 0 inside bank 4. A following push then stores its status byte at offset 0xFFFF, which brings the no-carry rule into reach. Long random command streams drive SP repeatedly across that boundary.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

  localparam int unsigned SP_W   = 16;
  localparam int unsigned STAT_W = 8;

  localparam logic [SP_W-1:0] VEC_BRK   = 16'hFFE0;
  localparam logic [SP_W-1:0] VEC_WAIT  = 16'hFFA0;
  localparam logic [SP_W-1:0] VEC_BOOT0 = 16'hFFC0;
  localparam logic [SP_W-1:0] VEC_BOOTN = 16'hFF50;

  typedef enum logic [2:0] {
    OP_CALL  = 3'd0,
    OP_RTS   = 3'd1,
    OP_BRK   = 3'd2,
    OP_WAI   = 3'd3,
    OP_RTI   = 3'd4,
    OP_RESET = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PUSH_PC,
    PH_PUSH_ST,
    PH_POP_ST,
    PH_POP_PC,
    PH_FIN
  } phase_e;

  function automatic logic op_is_irq(input op_e o);
    return (o == OP_BRK) || (o == OP_WAI);
  endfunction

  function automatic logic op_reads_vec(input op_e o);
    return (o == OP_BRK) || (o == OP_WAI) || (o == OP_RESET);
  endfunction

endpackage

// File: rtl/stk_seq_rst_sync.sv
module stk_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
  import stk_seq_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 8,
  parameter int unsigned CNT_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  output phase_e           phase,
  output op_e              op,
  output logic [CNT_W-1:0] cnt,
  output logic             accept,
  output logic             commit,
  output logic             done
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_BYTES - 1);

  phase_e           ph_q, ph_d;
  op_e              op_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             op_ok;
  logic             at_last;

  assign op_ok   = (cmd_op <= 3'(OP_RESET));
  assign accept  = (ph_q == PH_IDLE) && cmd_valid && op_ok;
  assign at_last = (cnt_q == CNT_LAST);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    commit = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (accept) begin
          cnt_d  = '0;
          cnt_en = 1'b1;
          case (op_e'(cmd_op))
            OP_CALL, OP_BRK, OP_WAI: ph_d = PH_PUSH_PC;
            OP_RTI:                  ph_d = PH_POP_ST;
            default:                 ph_d = PH_POP_PC;
          endcase
        end
      end
      PH_PUSH_PC: begin
        cnt_en = 1'b1;
        if (at_last) begin
          cnt_d = '0;
          if (op_q == OP_CALL) begin
            ph_d   = PH_FIN;
            commit = 1'b1;
          end else begin
            ph_d = PH_PUSH_ST;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_PUSH_ST: ph_d = PH_POP_PC;
      PH_POP_ST:  ph_d = PH_POP_PC;
      PH_POP_PC: begin
        cnt_en = 1'b1;
        if (at_last) begin
          cnt_d  = '0;
          ph_d   = PH_FIN;
          commit = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_FIN:  ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      op_q  <= OP_CALL;
      cnt_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (accept) op_q  <= op_e'(cmd_op);
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign phase = ph_q;
  assign op    = op_q;
  assign cnt   = cnt_q;
  assign done  = (ph_q == PH_FIN);

endmodule

// File: rtl/stk_seq_agen.sv
module stk_seq_agen
  import stk_seq_pkg::*;
#(
  parameter int unsigned MEM_AW     = 24,
  parameter int unsigned WORD_BYTES = 8,
  parameter int unsigned CNT_W      = 3,
  parameter int unsigned THREAD_IDX = 0
) (
  input  logic [MEM_AW-SP_W-1:0] bank,
  input  logic [SP_W-1:0]        sp,
  input  phase_e                 phase,
  input  op_e                    op,
  input  logic [CNT_W-1:0]       cnt,
  output logic [MEM_AW-1:0]      addr
);

  localparam int unsigned     BANK_W   = MEM_AW - SP_W;
  localparam logic [SP_W-1:0] BOOT_VEC = (THREAD_IDX == 0) ? VEC_BOOT0
                                       : VEC_BOOTN + SP_W'(8 * (THREAD_IDX - 1));

  logic [SP_W-1:0] cnt_x;
  logic [SP_W-1:0] offs;
  logic [SP_W-1:0] vec_base;
  logic            use_vec;

  assign cnt_x = SP_W'(cnt);

  always_comb begin
    case (op)
      OP_BRK:  vec_base = VEC_BRK;
      OP_WAI:  vec_base = VEC_WAIT;
      default: vec_base = BOOT_VEC;
    endcase
  end

  always_comb begin
    use_vec = 1'b0;
    offs    = sp;
    case (phase)
      PH_PUSH_PC: offs = sp - cnt_x;
      PH_PUSH_ST: offs = sp - SP_W'(WORD_BYTES);
      PH_POP_ST:  offs = sp + 16'd1;
      PH_POP_PC: begin
        if (op_reads_vec(op)) begin
          use_vec = 1'b1;
          offs    = vec_base + cnt_x;
        end else if (op == OP_RTI) begin
          offs = sp + 16'd2 + cnt_x;
        end else begin
          offs = sp + 16'd1 + cnt_x;
        end
      end
      default: offs = sp;
    endcase
  end

  assign addr = use_vec ? {{BANK_W{1'b0}}, offs} : {bank, offs};

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_seq_pkg::*;
#(
  parameter int unsigned PC_W       = 64,
  parameter int unsigned MEM_AW     = 24,
  parameter int unsigned THREAD_IDX = 0,
  parameter int unsigned IDIS_BIT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [PC_W-1:0]   cmd_target,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [7:0]        cur_status,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic [PC_W-1:0]   new_pc,
  output logic [15:0]       new_sp,
  output logic [7:0]        new_status
);

  localparam int unsigned WORD_BYTES = PC_W / 8;
  localparam int unsigned CNT_W      = $clog2(WORD_BYTES);
  localparam int unsigned BANK_W     = MEM_AW - SP_W;
  localparam logic [BANK_W-1:0] BANK = BANK_W'(THREAD_IDX + 1);
  localparam logic [STAT_W-1:0] IDIS_MASK = STAT_W'(1) << IDIS_BIT;
  localparam logic [SP_W-1:0]   SP_INIT   = '1;

  logic             rst_sync_n;
  phase_e           phase;
  op_e              op;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             commit;

  logic [PC_W-1:0]   sr_q, sr_d, tgt_q, pc_q, pc_d;
  logic              sr_en;
  logic [STAT_W-1:0] st_q, st_d, stat_q, stat_d;
  logic              st_en;
  logic [SP_W-1:0]   sp_q, sp_d;

  stk_seq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  stk_seq_ctrl #(
    .WORD_BYTES (WORD_BYTES),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .phase     (phase),
    .op        (op),
    .cnt       (cnt),
    .accept    (accept),
    .commit    (commit),
    .done      (done)
  );

  stk_seq_agen #(
    .MEM_AW     (MEM_AW),
    .WORD_BYTES (WORD_BYTES),
    .CNT_W      (CNT_W),
    .THREAD_IDX (THREAD_IDX)
  ) u_agen (
    .bank  (BANK),
    .sp    (sp_q),
    .phase (phase),
    .op    (op),
    .cnt   (cnt),
    .addr  (mem_addr)
  );

  assign mem_we    = (phase == PH_PUSH_PC) || (phase == PH_PUSH_ST);
  assign mem_en    = mem_we || (phase == PH_POP_ST) || (phase == PH_POP_PC);
  assign mem_wdata = (phase == PH_PUSH_ST) ? st_q : sr_q[PC_W-1 -: 8];

  // Byte shift register: shifts out toward the top on push, fills from the top on pop.
  always_comb begin
    sr_d  = sr_q;
    sr_en = 1'b0;
    if (accept) begin
      sr_d  = cur_pc;
      sr_en = 1'b1;
    end else if (phase == PH_PUSH_PC) begin
      sr_d  = sr_q << 8;
      sr_en = 1'b1;
    end else if (phase == PH_POP_PC) begin
      sr_d  = {mem_rdata, sr_q[PC_W-1:8]};
      sr_en = 1'b1;
    end
  end

  always_comb begin
    st_d  = st_q;
    st_en = 1'b0;
    if (accept) begin
      st_d  = cur_status;
      st_en = 1'b1;
    end else if (phase == PH_POP_ST) begin
      st_d  = mem_rdata;
      st_en = 1'b1;
    end
  end

  always_comb begin
    pc_d   = (op == OP_CALL) ? tgt_q : {mem_rdata, sr_q[PC_W-1:8]};
    stat_d = op_is_irq(op) ? (st_q | IDIS_MASK) : st_q;
    case (op)
      OP_CALL:        sp_d = sp_q - SP_W'(WORD_BYTES);
      OP_BRK, OP_WAI: sp_d = sp_q - SP_W'(WORD_BYTES + 1);
      OP_RTS:         sp_d = sp_q + SP_W'(WORD_BYTES);
      OP_RTI:         sp_d = sp_q + SP_W'(WORD_BYTES + 1);
      default:        sp_d = SP_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sr_q   <= '0;
      tgt_q  <= '0;
      st_q   <= '0;
      pc_q   <= '0;
      sp_q   <= SP_INIT;
      stat_q <= '0;
    end else begin
      if (sr_en)  sr_q  <= sr_d;
      if (accept) tgt_q <= cmd_target;
      if (st_en)  st_q  <= st_d;
      if (commit) begin
        pc_q   <= pc_d;
        sp_q   <= sp_d;
        stat_q <= stat_d;
      end
    end
  end

  assign new_pc     = pc_q;
  assign new_sp     = sp_q;
  assign new_status = stat_q;

endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
  parameter int unsigned PC_W       = 64,
  parameter int unsigned MEM_AW     = 24,
  parameter int unsigned THREAD_IDX = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_en,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              done,
  input logic [PC_W-1:0]   new_pc,
  input logic [15:0]       new_sp,
  input logic [7:0]        new_status
);

  localparam int unsigned BANK_W = MEM_AW - 16;
  localparam logic [BANK_W-1:0] BANK = BANK_W'(THREAD_IDX + 1);

  logic [BANK_W-1:0] hi;
  assign hi = mem_addr[MEM_AW-1:16];

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_en);

  a_r1_bank_field: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ((hi == BANK) || ((hi == '0) && (mem_addr[15:8] == 8'hFF))));

  a_r12_hold_sp: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(new_sp));

  a_r12_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(new_pc) && $stable(new_status)));

endmodule

bind stk_seq stk_seq_chk #(
  .PC_W       (PC_W),
  .MEM_AW     (MEM_AW),
  .THREAD_IDX (THREAD_IDX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .mem_en     (mem_en),
  .mem_addr   (mem_addr),
  .done       (done),
  .new_pc     (new_pc),
  .new_sp     (new_sp),
  .new_status (new_status)
);

// File: tb/stk_seq_test.sv
`timescale 1ns/1ps
module stk_seq_test;

  localparam int unsigned TID  = 3;
  localparam logic [7:0]  BANK = 8'(TID + 1);
  localparam logic [15:0] BOOT = 16'hFF60;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [63:0] cmd_target, cur_pc;
  logic [7:0]  cur_status;
  logic        mem_en, mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        done;
  logic [63:0] new_pc;
  logic [15:0] new_sp;
  logic [7:0]  new_status;

  int nchk = 0;
  int nfail = 0;
  logic [15:0] msp;
  logic [63:0] mpc;
  logic [7:0]  mst;

  always #2.5 clk = ~clk;

  stk_seq #(.THREAD_IDX(TID)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_target(cmd_target), .cur_pc(cur_pc), .cur_status(cur_status),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
    .new_pc(new_pc), .new_sp(new_sp), .new_status(new_status)
  );

  logic [7:0] mem [logic [23:0]];
  int unsigned wr_cnt = 0;

  function automatic logic [7:0] peek(input logic [23:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) if (mem_we) begin
    mem[mem_addr] = mem_wdata;
    wr_cnt = wr_cnt + 1;
  end

  always @(mem_addr or wr_cnt) mem_rdata = peek(mem_addr);

  function automatic logic [23:0] sa(input logic [15:0] s);
    return {BANK, s};
  endfunction

  function automatic logic [63:0] vec_le(input logic [15:0] base);
    logic [63:0] v = '0;
    for (int j = 7; j >= 0; j--) v = {v[55:0], peek({8'h00, base + 16'(j)})};
    return v;
  endfunction

  function automatic logic [63:0] pop_le(input logic [15:0] first);
    logic [63:0] v = '0;
    for (int j = 7; j >= 0; j--) v = {v[55:0], peek(sa(first + 16'(j)))};
    return v;
  endfunction

  function automatic logic [63:0] push_be(input logic [15:0] top);
    logic [63:0] v = '0;
    for (int i = 0; i < 8; i++) v = {v[55:0], peek(sa(top - 16'(i)))};
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  // inject > 1: present a reset command at that cycle of the sequence (R10)
  task automatic run_cmd(input logic [2:0] op, input logic [63:0] tgt,
                         input logic [63:0] pc, input logic [7:0] st, input int inject);
    logic [63:0] e_pc;
    logic [15:0] e_sp;
    logic [7:0]  e_st;
    int          e_acc, k, acc;
    string       req;
    bit          got;
    e_st = st;
    case (op)
      3'd0: begin req = "R2"; e_acc = 8;  e_pc = tgt;                 e_sp = msp - 16'd8; end
      3'd1: begin req = "R5"; e_acc = 8;  e_pc = pop_le(msp + 16'd1); e_sp = msp + 16'd8; end
      3'd2: begin req = "R3"; e_acc = 17; e_pc = vec_le(16'hFFE0);    e_sp = msp - 16'd9; e_st = st | 8'h04; end
      3'd3: begin req = "R4"; e_acc = 17; e_pc = vec_le(16'hFFA0);    e_sp = msp - 16'd9; e_st = st | 8'h04; end
      3'd4: begin req = "R6"; e_acc = 9;  e_pc = pop_le(msp + 16'd2); e_sp = msp + 16'd9;
                  e_st = peek(sa(msp + 16'd1)); end
      default: begin req = "R7"; e_acc = 8; e_pc = vec_le(BOOT); e_sp = 16'hFFFF; end
    endcase
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_target = tgt; cur_pc = pc; cur_status = st;
    k = 0; acc = 0; got = 1'b0;
    while (k < 60) begin
      @(posedge clk); @(negedge clk);
      k++;
      if (k == 1) cmd_valid = 1'b0;
      if (inject > 1 && k == inject) begin cmd_valid = 1'b1; cmd_op = 3'd5; end
      if (inject > 1 && k == inject + 1) cmd_valid = 1'b0;
      if (done) begin got = 1'b1; break; end
      if (mem_en) acc++;
    end
    chk(got, "R9", "done seen", 64'(got), 64'd1);
    chk(k == e_acc + 1, "R9", "latency", 64'(k), 64'(e_acc + 1));
    chk(acc == e_acc, "R9", "access count", 64'(acc), 64'(e_acc));
    chk(new_pc == e_pc, req, "pc", new_pc, e_pc);
    chk(new_sp == e_sp, req, "sp", 64'(new_sp), 64'(e_sp));
    chk(new_status == e_st, req, "status", 64'(new_status), 64'(e_st));
    if (op == 3'd0 || op == 3'd2 || op == 3'd3)
      chk(push_be(msp) == pc, req, "pushed pc", push_be(msp), pc);
    if (op == 3'd2 || op == 3'd3)
      chk(peek(sa(msp - 16'd8)) == st, req, "pushed status",
          64'(peek(sa(msp - 16'd8))), 64'(st));
    msp = e_sp; mpc = e_pc; mst = e_st;
  endtask

  task automatic quiet(input int n, input string req);
    int ev = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mem_en || done) ev++;
    end
    chk(ev == 0, req, "no activity", 64'(ev), 64'd0);
    chk(new_pc == mpc && new_sp == msp && new_status == mst, req, "outputs held",
        {new_sp, new_status, new_pc[39:0]}, {msp, mst, mpc[39:0]});
  endtask

  task automatic bad_op(input logic [2:0] op);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    quiet(6, "R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd9137));
    for (int a = 16'hFF00; a <= 16'hFFFF; a++) mem[24'(a)] = 8'($urandom());
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0;
    cmd_target = '0; cur_pc = '0; cur_status = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8: reset state
    msp = 16'hFFFF; mpc = '0; mst = '0;
    chk(new_sp == 16'hFFFF, "R8", "sp", 64'(new_sp), 64'hFFFF);
    chk(new_pc == '0, "R8", "pc", new_pc, 64'd0);
    chk(new_status == 8'h00, "R8", "status", 64'(new_status), 64'd0);
    quiet(3, "R8");
    // R7 boot vector of thread 3 at 0xFF60
    run_cmd(3'd5, 64'd0, 64'd0, 8'h81, 0);
    // R1: pop from 0xFFFF wraps to offset 0 inside the bank
    run_cmd(3'd1, 64'd0, 64'd0, 8'h11, 0);
    // R1: push from 0x0007 puts status at offset 0xFFFF of the same bank
    run_cmd(3'd2, 64'd0, 64'h0123_4567_89AB_CDEF, 8'h3A, 0);
    chk(peek(sa(16'hFFFF)) == 8'h3A, "R1", "status at bank top",
        64'(peek(sa(16'hFFFF))), 64'h3A);
    run_cmd(3'd4, 64'd0, 64'd0, 8'h00, 0);
    chk(new_pc == 64'h0123_4567_89AB_CDEF, "R6", "return address round trip",
        new_pc, 64'h0123_4567_89AB_CDEF);
    run_cmd(3'd3, 64'd0, 64'hFEDC_BA98_7654_3210, 8'h04, 0);
    // R10: reset command injected mid-call is ignored
    run_cmd(3'd0, 64'hDEAD_BEEF_0000_1234, 64'h1111_2222_3333_4444, 8'h5C, 4);
    quiet(20, "R10");
    bad_op(3'd6);
    bad_op(3'd7);
    run_cmd(3'd1, 64'd0, 64'd0, 8'h77, 0);
    chk(new_pc == 64'h1111_2222_3333_4444, "R5", "call/return round trip",
        new_pc, 64'h1111_2222_3333_4444);
    for (int n = 0; n < 300; n++) begin
      logic [2:0]  op;
      logic [63:0] t, p;
      op = 3'($urandom() % 6);
      t  = {$urandom(), $urandom()};
      p  = {$urandom(), $urandom()};
      run_cmd(op, t, p, 8'($urandom()), ((n % 37) == 5) ? 3 : 0);
    end
    quiet(5, "R11");
    finish_run();
  end

endmodule